// File: doc/BRIEF.md
# Self-ID Reception Status Tracker

This block follows self-ID reception on a serial bus and presents the result as one 32-bit read-only status word. A generation counter advances on every detected bus reset and wraps around. A quadlet counter counts the quadlets stored into the self-ID buffer, including the header quadlet. An error flag records a failed reception. The buffer, packet decoding, DMA and the host bus sit outside the block. The block only sees single-cycle event pulses from that logic.

Software reads the word through a small registered read port at a fixed offset. Writes arriving at the block are dropped. Field positions in the word are fixed because driver code decodes them.

Top module: `sid_status_reg`

## Requirements
- R1: After synchronous reset every field is 0, and a read at the register offset returns 32'h0000_0000.
- R2: Each cycle with `bus_reset_i` high increments the 8-bit generation field, which reads at bits 23:16.
- R3: The generation field wraps from 255 to 0 on the next bus reset.
- R4: Each cycle with `quad_wr_i` high increments the 9-bit quadlet count, which reads at bits 10:2.
- R5: `rx_start_i` clears the quadlet count to 0. If `quad_wr_i` is high in the same cycle, that quadlet is the first of the new reception and the count becomes 1.
- R6: The quadlet count holds at 511 when further quadlets arrive.
- R7: A cycle with `hw_err_i` or `host_err_i` high sets the error flag at bit 31 from the next cycle on.
- R8: On `rx_done_i` the error flag clears only if no error pulse has occurred since the last `rx_start_i` (counting the cycle of `rx_start_i` itself and the cycle of `rx_done_i`). Otherwise it stays set.
- R9: Bits 30:24, 15:11 and 1:0 always read as 0.
- R10: When `bus_reset_i` and `rx_start_i` are high in the same cycle, the generation field increments and the count clears in that cycle.
- R11: A read with `rd_en_i` high returns data in the next cycle, with `rd_valid_o` high. The data is the register as it stood before that edge when `rd_addr_i` equals offset 8'h68, and 0 for any other address.
- R12: `wr_en_i`, `wr_addr_i` and `wr_data_i` have no effect on any field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset_i | input | 1 | Bus reset detected (one-cycle pulse) |
| rx_start_i | input | 1 | Self-ID reception begins |
| quad_wr_i | input | 1 | One quadlet stored into the self-ID buffer |
| hw_err_i | input | 1 | Receive-side hardware error |
| host_err_i | input | 1 | Host-bus write error while storing self-ID data |
| rx_done_i | input | 1 | Self-ID reception complete |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 8 | Read byte offset |
| wr_en_i | input | 1 | Write request (ignored) |
| wr_addr_i | input | 8 | Write byte offset (ignored) |
| wr_data_i | input | 32 | Write data (ignored) |
| rd_data_o | output | 32 | Registered read data |
| rd_valid_o | output | 1 | Read data valid |

## Verification
The assertions assume every event input is sampled once per clock and means one event per high cycle. They also assume an error pulse always belongs to the reception most recently opened by `rx_start_i`. Beyond that, they accept any mix of coincident pulses, because the priorities among start, strobe, error and completion are defined. The stimulus keeps every pulse to whole clock cycles driven away from the active edge. It mixes directed coincident cases with random pulses at modest densities, so that receptions open and close many times and some receptions carry errors while others stay clean.

// File: rtl/sid_pkg.sv
package sid_pkg;
  localparam int REG_W   = 32;
  localparam int ERR_BIT = 31;
  localparam int GEN_LSB = 16;
  localparam int CNT_LSB = 2;
endpackage

// File: rtl/sid_gen_ctr.sv
module sid_gen_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_i,
  output logic [W-1:0] gen_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) gen_o <= '0;
    else if (inc_i) gen_o <= gen_o + 1'b1;
  end

  assert_gen_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !inc_i |=> $stable(gen_o));
  assert_gen_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (inc_i && gen_o == TOP) |=> gen_o == '0);
endmodule

// File: rtl/sid_quad_ctr.sv
module sid_quad_ctr #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         stb_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) cnt_o <= '0;
    else if (clr_i) cnt_o <= {{(W-1){1'b0}}, stb_i};
    else if (stb_i && cnt_o != MAXV) cnt_o <= cnt_o + 1'b1;
  end

  assert_cnt_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !stb_i) |=> cnt_o == '0);
  assert_cnt_sat_R6: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && cnt_o == MAXV) |=> cnt_o == MAXV);
  assert_cnt_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !stb_i) |=> $stable(cnt_o));
endmodule

// File: rtl/sid_err_track.sv
module sid_err_track (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic hw_err_i,
  input  logic host_err_i,
  input  logic done_i,
  output logic flag_o
);
  logic err_any;
  logic pend_q;

  assign err_any = hw_err_i | host_err_i;

  // pend_q: an error was seen since the reception opened
  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else if (start_i) pend_q <= err_any;
    else if (err_any) pend_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else if (err_any) flag_o <= 1'b1;
    else if (done_i && !pend_q) flag_o <= 1'b0;
  end

  assert_err_set_R7: assert property (@(posedge clk) disable iff (rst)
    err_any |=> flag_o);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !done_i) |=> flag_o);
  assert_err_clean_R8: assert property (@(posedge clk) disable iff (rst)
    (done_i && !err_any && !pend_q) |=> !flag_o);
endmodule

// File: rtl/sid_status_reg.sv
module sid_status_reg
  import sid_pkg::*;
#(
  parameter int          GEN_W  = 8,
  parameter int          CNT_W  = 9,
  parameter int          ADDR_W = 8,
  parameter logic [7:0]  REG_OFFSET = 8'h68
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_reset_i,
  input  logic              rx_start_i,
  input  logic              quad_wr_i,
  input  logic              hw_err_i,
  input  logic              host_err_i,
  input  logic              rx_done_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              rd_valid_o
);
  localparam logic [ADDR_W-1:0] OFF = ADDR_W'(REG_OFFSET);
  localparam logic [REG_W-1:0] FIELD_MASK =
      (REG_W'(1) << ERR_BIT)
    | (((REG_W'(1) << GEN_W) - 1) << GEN_LSB)
    | (((REG_W'(1) << CNT_W) - 1) << CNT_LSB);

  logic [GEN_W-1:0] gen;
  logic [CNT_W-1:0] cnt;
  logic             err_flag;
  logic [REG_W-1:0] reg_word;
  logic             rd_hit;
  logic             unused_wr;

  assign unused_wr = ^{wr_en_i, wr_addr_i, wr_data_i};

  sid_gen_ctr #(.W(GEN_W)) u_gen (
    .clk(clk), .rst(rst), .inc_i(bus_reset_i), .gen_o(gen)
  );

  sid_quad_ctr #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(rx_start_i), .stb_i(quad_wr_i), .cnt_o(cnt)
  );

  sid_err_track u_err (
    .clk(clk), .rst(rst), .start_i(rx_start_i), .hw_err_i(hw_err_i),
    .host_err_i(host_err_i), .done_i(rx_done_i), .flag_o(err_flag)
  );

  always_comb begin
    reg_word = '0;
    reg_word[ERR_BIT] = err_flag;
    reg_word[GEN_LSB +: GEN_W] = gen;
    reg_word[CNT_LSB +: CNT_W] = cnt;
  end

  assign rd_hit = rd_en_i && (rd_addr_i == OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      rd_data_o  <= rd_hit ? reg_word : '0;
    end
  end

  assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_data_o & ~FIELD_MASK) == '0);
  assert_miss_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_addr_i != OFF) |=> rd_data_o == '0);
  assert_rd_valid_R11: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rd_valid_o);
  assert_coincide_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_reset_i && rx_start_i && !quad_wr_i) |=> (cnt == '0 && gen == $past(gen) + 1'b1));
endmodule

// File: tb/sid_status_reg_tb.sv
module sid_status_reg_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_reset_i = 0, rx_start_i = 0, quad_wr_i = 0;
  logic hw_err_i = 0, host_err_i = 0, rx_done_i = 0;
  logic rd_en_i = 0, wr_en_i = 0;
  logic [7:0]  rd_addr_i = 8'h68, wr_addr_i = 8'h00;
  logic [31:0] wr_data_i = 32'h0;
  logic [31:0] rd_data_o;
  logic        rd_valid_o;

  int vectors = 0;
  int fails   = 0;

  // reference state
  int m_gen = 0, m_cnt = 0;
  bit m_err = 0, m_pend = 0, m_vld = 0;
  logic [31:0] m_rd = 0;

  always #10 clk = ~clk;

  sid_status_reg u_dut (
    .clk(clk), .rst(rst), .bus_reset_i(bus_reset_i), .rx_start_i(rx_start_i),
    .quad_wr_i(quad_wr_i), .hw_err_i(hw_err_i), .host_err_i(host_err_i),
    .rx_done_i(rx_done_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
  );

  function automatic logic [31:0] pack_word();
    logic [31:0] w = 32'h0;
    w[31]    = m_err;
    w[23:16] = m_gen[7:0];
    w[10:2]  = m_cnt[8:0];
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    bit eany;
    eany = hw_err_i | host_err_i;
    if (rst) begin
      m_gen = 0; m_cnt = 0; m_err = 0; m_pend = 0; m_vld = 0; m_rd = 0;
    end else begin
      m_vld = rd_en_i;
      m_rd  = (rd_en_i && rd_addr_i == 8'h68) ? pack_word() : 32'h0;
      if (bus_reset_i) m_gen = (m_gen + 1) % 256;
      if (rx_start_i) m_cnt = quad_wr_i ? 1 : 0;
      else if (quad_wr_i && m_cnt < 511) m_cnt = m_cnt + 1;
      if (eany) m_err = 1;
      else if (rx_done_i && !m_pend) m_err = 0;
      if (rx_start_i) m_pend = eany;
      else if (eany) m_pend = 1;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R11 valid", {31'h0, rd_valid_o}, {31'h0, m_vld});
    check("R9 reserved", rd_data_o & 32'h7F00_F803, m_rd & 32'h7F00_F803);
    check("R7/R8 error", {31'h0, rd_data_o[31]}, {31'h0, m_rd[31]});
    check("R2 generation", {24'h0, rd_data_o[23:16]}, {24'h0, m_rd[23:16]});
    check("R4 count", {23'h0, rd_data_o[10:2]}, {23'h0, m_rd[10:2]});
    bus_reset_i = 0; rx_start_i = 0; quad_wr_i = 0;
    hw_err_i = 0; host_err_i = 0; rx_done_i = 0;
    rd_en_i = 0; rd_addr_i = 8'h68; wr_en_i = 0;
  endtask

  task automatic read_reg(output logic [31:0] v);
    rd_en_i = 1; rd_addr_i = 8'h68;
    tick();
    v = rd_data_o;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int g0;
    @(negedge clk);
    rst = 1; tick(); tick(); rst = 0;
    read_reg(v); check("R1 reset word", v, 32'h0);

    // R10: bus reset and start together
    quad_wr_i = 1; tick(); quad_wr_i = 1; tick();
    bus_reset_i = 1; rx_start_i = 1; tick();
    read_reg(v); check("R10 gen", {24'h0, v[23:16]}, 32'd1);
    check("R10 count", {23'h0, v[10:2]}, 32'd0);

    // R4 counting, R5 start with strobe
    for (int i = 0; i < 3; i++) begin quad_wr_i = 1; tick(); end
    read_reg(v); check("R4 three quadlets", {23'h0, v[10:2]}, 32'd3);
    rx_start_i = 1; quad_wr_i = 1; tick();
    read_reg(v); check("R5 start plus strobe", {23'h0, v[10:2]}, 32'd1);

    // R7 / R8
    hw_err_i = 1; tick();
    read_reg(v); check("R7 hw error sets", {31'h0, v[31]}, 32'd1);
    rx_done_i = 1; tick();
    read_reg(v); check("R8 stays after errored reception", {31'h0, v[31]}, 32'd1);
    rx_start_i = 1; tick(); quad_wr_i = 1; tick(); rx_done_i = 1; tick();
    read_reg(v); check("R8 clean reception clears", {31'h0, v[31]}, 32'd0);
    host_err_i = 1; tick();
    read_reg(v); check("R7 host error sets", {31'h0, v[31]}, 32'd1);
    rx_start_i = 1; tick(); rx_done_i = 1; hw_err_i = 1; tick();
    read_reg(v); check("R8 error on done cycle keeps flag", {31'h0, v[31]}, 32'd1);

    // R12 writes ignored
    read_reg(v); g0 = v;
    wr_en_i = 1; wr_addr_i = 8'h68; wr_data_i = 32'hFFFF_FFFF; tick();
    wr_en_i = 1; wr_addr_i = 8'h68; wr_data_i = 32'h0; tick();
    read_reg(v); check("R12 write ignored", v, 32'(g0));

    // R11 other address
    rd_en_i = 1; rd_addr_i = 8'h6C; tick();
    check("R11 miss returns zero", rd_data_o, 32'h0);

    // R6 saturation
    rx_start_i = 1; tick();
    for (int i = 0; i < 520; i++) begin quad_wr_i = 1; tick(); end
    read_reg(v); check("R6 saturate", {23'h0, v[10:2]}, 32'd511);

    // R3 wrap
    while (m_gen != 255) begin bus_reset_i = 1; tick(); end
    read_reg(v); check("R3 at top", {24'h0, v[23:16]}, 32'd255);
    bus_reset_i = 1; tick();
    read_reg(v); check("R3 wrapped", {24'h0, v[23:16]}, 32'd0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bus_reset_i = ($urandom_range(0, 15) == 0);
      rx_start_i  = ($urandom_range(0, 11) == 0);
      quad_wr_i   = ($urandom_range(0, 2) == 0);
      hw_err_i    = ($urandom_range(0, 40) == 0);
      host_err_i  = ($urandom_range(0, 60) == 0);
      rx_done_i   = ($urandom_range(0, 11) == 0);
      rd_en_i     = ($urandom_range(0, 1) == 0);
      rd_addr_i   = ($urandom_range(0, 5) == 0) ? 8'h64 : 8'h68;
      wr_en_i     = ($urandom_range(0, 7) == 0);
      wr_addr_i   = 8'h68;
      wr_data_i   = $urandom;
      if (i == 2000) rst = 1;
      if (i == 2001) rst = 0;
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule